// File: doc/BRIEF.md
# Lockable Configuration Key Vault

This block holds two decryption key sets for a configuration loader and decides which configuration streams the loader may accept. Keys arrive through a serial command port. While the block is still open, the keys can be read back for checking. A lock command then moves it into secure mode.

Before lock, the loader may run exactly one unencrypted stream. After lock, only encrypted streams are accepted, and each must name key set 0 or key set 1. For an accepted encrypted stream, the chosen key is presented to an external decryptor. The end-of-stream validity flag decides whether startup completes. A wipe command leaves secure mode, clears both keys and invalidates the loaded configuration.

The key registers, the lock state and the record of the one unencrypted stream sit behind their own reset input. The functional reset therefore leaves them intact.

Top module: `cfg_key_vault`

## Requirements
- R1: Before lock, a write command stores a 56-bit key into the set given by its slot bit (0 or 1). A read command then shows that set's key on `rb_key`, and the two sets are independent.
- R2: Once locked, `secure` is high and `rb_key` shows all zeros. A value captured before the lock is cleared, and every later read also returns zero.
- R3: After lock, a write command leaves both keys unchanged and sets the sticky `cmd_err` flag. `cmd_err` is cleared only by the functional reset.
- R4: Before lock, only one unencrypted stream is accepted and a second one is rejected. An encrypted header (`st_enc`=1) is rejected while unlocked.
- R5: After lock, an unencrypted header is rejected: `cfg_fail` goes high and `cfg_done` stays low.
- R6: After lock, a header whose `st_ksel` is 2 or 3 is rejected.
- R7: An accepted encrypted header raises `dec_en` and drives `dec_key` with the selected set's key and `dec_sel` with its index, one cycle after `st_start`.
- R8: At `st_end`, `st_ok`=1 sets `cfg_done`. `st_ok`=0 leaves `cfg_done` low and raises `cfg_fail`.
- R9: A functional reset clears `cfg_done`, `cfg_fail` and `cmd_err`, but keeps both keys and the lock.
- R10: Pulsing only `key_rst_n` clears both keys and the lock.
- R11: The wipe command clears both keys and the lock, drops `cfg_done` and aborts any running stream. A fresh unencrypted stream is then allowed.
- R12: A wipe that takes effect in the same cycle as `st_end` with `st_ok`=1 wins, and `cfg_done` stays low.
- R13: The command frame is 60 bits, shifted in least significant bit first while `tp_shift` is high. Bits [55:0] are key data, bit 56 is the slot, and bits [59:57] are the opcode: 1 write, 2 read, 3 lock, 4 wipe, any other value does nothing. The frame is applied when `tp_update` pulses and takes effect on the second rising edge after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous |
| key_rst_n | input | 1 | Key-domain reset, active low, asynchronous |
| tp_shift | input | 1 | Shift one command bit in |
| tp_sdi | input | 1 | Serial command data |
| tp_update | input | 1 | Apply the shifted frame |
| rb_key | output | 56 | Key readback |
| cmd_err | output | 1 | Sticky: key write refused while locked |
| secure | output | 1 | Lock state |
| st_start | input | 1 | Stream header strobe |
| st_enc | input | 1 | Header encrypted marker |
| st_ksel | input | 2 | Header key-set select |
| st_end | input | 1 | Stream end strobe |
| st_ok | input | 1 | Stream validity at end |
| dec_en | output | 1 | Decryptor enable |
| dec_key | output | 56 | Key routed to decryptor |
| dec_sel | output | 1 | Index of routed key set |
| cfg_done | output | 1 | Startup complete |
| cfg_fail | output | 1 | Stream rejected or invalid |

## Verification
A wipe command and the end of a running stream can land on the same clock edge. This is the collision the bench provokes on purpose. It releases the command's update pulse one cycle before raising `st_end` with a good validity flag, so the decoded wipe and the stream end meet at the next edge. The result passes only if `cfg_done` stays low, the lock has dropped, and a following readback shows an erased key.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_LOCK  = 3'd3,
    OP_WIPE  = 3'd4
  } kv_op_e;

  typedef enum logic [1:0] {
    GS_IDLE,
    GS_RUN,
    GS_DONE,
    GS_FAIL
  } gate_st_e;

endpackage

// File: rtl/kv_rst_sync.sv
module kv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];

endmodule

// File: rtl/kv_cmd_shifter.sv
module kv_cmd_shifter
  import keyvault_pkg::*;
#(
  parameter int KEY_W  = 56,
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              sdi,
  input  logic              update,
  output logic              cmd_valid,
  output kv_op_e            cmd_op,
  output logic [SLOT_W-1:0] cmd_slot,
  output logic [KEY_W-1:0]  cmd_data
);

  localparam int OP_W    = 3;
  localparam int FRAME_W = KEY_W + SLOT_W + OP_W;

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               vld_q;
  kv_op_e             op_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [KEY_W-1:0]   data_q;

  always_comb begin
    frame_d = frame_q;
    if (shift) frame_d = {sdi, frame_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else if (shift) frame_q <= frame_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      op_q   <= OP_NOP;
      slot_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= update;
      if (update) begin
        op_q   <= kv_op_e'(frame_q[FRAME_W-1 -: OP_W]);
        slot_q <= frame_q[KEY_W +: SLOT_W];
        data_q <= frame_q[KEY_W-1:0];
      end
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_op    = op_q;
  assign cmd_slot  = slot_q;
  assign cmd_data  = data_q;

  // R13
  cmd_from_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(update));

endmodule

// File: rtl/kv_key_vault.sv
module kv_key_vault
  import keyvault_pkg::*;
#(
  parameter int KEY_W  = 56,
  parameter int NSETS  = 2,
  parameter int SLOT_W = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        krst_n,
  input  logic                        cmd_valid,
  input  kv_op_e                      cmd_op,
  input  logic [SLOT_W-1:0]           cmd_slot,
  input  logic [KEY_W-1:0]            cmd_data,
  input  logic                        plain_take,
  output logic [NSETS-1:0][KEY_W-1:0] keys_o,
  output logic                        locked_o,
  output logic                        plain_used_o,
  output logic                        wipe_o,
  output logic [KEY_W-1:0]            rb_key_o,
  output logic                        cmd_err_o
);

  logic [KEY_W-1:0] key_q [NSETS];
  logic             locked_q, locked_d;
  logic             used_q, used_d;
  logic [KEY_W-1:0] rb_q, rb_d;
  logic             rb_en;
  logic             err_q, err_d;
  logic             do_write, do_read, do_lock, do_wipe;

  assign do_write = cmd_valid && (cmd_op == OP_WRITE);
  assign do_read  = cmd_valid && (cmd_op == OP_READ);
  assign do_lock  = cmd_valid && (cmd_op == OP_LOCK);
  assign do_wipe  = cmd_valid && (cmd_op == OP_WIPE);
  assign wipe_o   = do_wipe;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic             en;
    logic [KEY_W-1:0] nxt;

    always_comb begin
      en  = 1'b0;
      nxt = key_q[g];
      if (do_wipe) begin
        en  = 1'b1;
        nxt = '0;
      end else if (do_write && !locked_q && (cmd_slot == SLOT_W'(g))) begin
        en  = 1'b1;
        nxt = cmd_data;
      end
    end

    always_ff @(posedge clk or negedge krst_n) begin
      if (!krst_n) key_q[g] <= '0;
      else if (en) key_q[g] <= nxt;
    end

    // R3
    key_hold_chk: assert property (@(posedge clk) disable iff (!krst_n)
      (locked_q && !do_wipe) |=> $stable(key_q[g]));
  end

  always_comb begin
    for (int i = 0; i < NSETS; i++) keys_o[i] = key_q[i];
  end

  always_comb begin
    locked_d = locked_q;
    if (do_wipe)      locked_d = 1'b0;
    else if (do_lock) locked_d = 1'b1;
    used_d = used_q;
    if (do_wipe)         used_d = 1'b0;
    else if (plain_take) used_d = 1'b1;
  end

  always_ff @(posedge clk or negedge krst_n) begin
    if (!krst_n) begin
      locked_q <= 1'b0;
      used_q   <= 1'b0;
    end else begin
      locked_q <= locked_d;
      used_q   <= used_d;
    end
  end

  always_comb begin
    rb_en = 1'b0;
    rb_d  = rb_q;
    err_d = err_q;
    if (do_wipe || do_lock) begin
      rb_en = 1'b1;
      rb_d  = '0;
    end else if (do_read) begin
      rb_en = 1'b1;
      if (!locked_q && (int'(cmd_slot) < NSETS)) rb_d = key_q[cmd_slot];
      else rb_d = '0;
    end
    if (do_write && locked_q) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (rb_en) rb_q <= rb_d;
      err_q <= err_d;
    end
  end

  assign locked_o     = locked_q;
  assign plain_used_o = used_q;
  assign rb_key_o     = rb_q;
  assign cmd_err_o    = err_q;

  // R2
  rb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !krst_n)
    locked_q |-> (rb_q == '0));

endmodule

// File: rtl/kv_stream_gate.sv
module kv_stream_gate
  import keyvault_pkg::*;
#(
  parameter int KEY_W  = 56,
  parameter int NSETS  = 2,
  parameter int KSEL_W = 2,
  parameter int SLOT_W = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        krst_n,
  input  logic                        locked,
  input  logic                        plain_used,
  input  logic [NSETS-1:0][KEY_W-1:0] keys,
  input  logic                        wipe,
  input  logic                        st_start,
  input  logic                        st_enc,
  input  logic [KSEL_W-1:0]           st_ksel,
  input  logic                        st_end,
  input  logic                        st_ok,
  output logic                        plain_take,
  output logic                        dec_en,
  output logic [KEY_W-1:0]            dec_key,
  output logic [SLOT_W-1:0]           dec_sel,
  output logic                        cfg_done,
  output logic                        cfg_fail
);

  gate_st_e          state_q, state_d;
  logic              enc_q, enc_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [SLOT_W-1:0] sel_q, sel_d;
  logic              hdr_ok;
  logic              sel_in_range;

  assign sel_in_range = int'(st_ksel) < NSETS;
  assign hdr_ok = locked ? (st_enc && sel_in_range) : (!st_enc && !plain_used);
  assign plain_take = st_start && (state_q != GS_RUN) && !wipe && !locked && hdr_ok;

  always_comb begin
    state_d = state_q;
    enc_d   = enc_q;
    key_d   = key_q;
    sel_d   = sel_q;
    if (wipe) begin
      state_d = GS_IDLE;
      enc_d   = 1'b0;
      key_d   = '0;
      sel_d   = '0;
    end else begin
      case (state_q)
        GS_RUN: begin
          if (st_end) begin
            state_d = st_ok ? GS_DONE : GS_FAIL;
            enc_d   = 1'b0;
            key_d   = '0;
            sel_d   = '0;
          end
        end
        default: begin
          if (st_start) begin
            if (hdr_ok) begin
              state_d = GS_RUN;
              enc_d   = st_enc;
              sel_d   = st_ksel[SLOT_W-1:0];
              key_d   = st_enc ? keys[st_ksel[SLOT_W-1:0]] : '0;
            end else begin
              state_d = GS_FAIL;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      enc_q   <= 1'b0;
      key_q   <= '0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      enc_q   <= enc_d;
      key_q   <= key_d;
      sel_q   <= sel_d;
    end
  end

  assign dec_en   = (state_q == GS_RUN) && enc_q;
  assign dec_key  = key_q;
  assign dec_sel  = sel_q;
  assign cfg_done = (state_q == GS_DONE);
  assign cfg_fail = (state_q == GS_FAIL);

  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(st_end && st_ok));

  // R11
  wipe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (!cfg_done && !dec_en));

  // R7
  enc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n || !krst_n)
    dec_en |-> locked);

endmodule

// File: rtl/cfg_key_vault.sv
module cfg_key_vault
  import keyvault_pkg::*;
#(
  parameter int KEY_W  = 56,
  parameter int NSETS  = 2,
  parameter int KSEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 key_rst_n,
  input  logic                 tp_shift,
  input  logic                 tp_sdi,
  input  logic                 tp_update,
  output logic [KEY_W-1:0]     rb_key,
  output logic                 cmd_err,
  output logic                 secure,
  input  logic                 st_start,
  input  logic                 st_enc,
  input  logic [KSEL_W-1:0]    st_ksel,
  input  logic                 st_end,
  input  logic                 st_ok,
  output logic                 dec_en,
  output logic [KEY_W-1:0]     dec_key,
  output logic [(NSETS>1 ? $clog2(NSETS) : 1)-1:0] dec_sel,
  output logic                 cfg_done,
  output logic                 cfg_fail
);

  localparam int SLOT_W = (NSETS > 1) ? $clog2(NSETS) : 1;

  logic                        frst_n, krst_n;
  logic                        cmd_valid;
  kv_op_e                      cmd_op;
  logic [SLOT_W-1:0]           cmd_slot;
  logic [KEY_W-1:0]            cmd_data;
  logic [NSETS-1:0][KEY_W-1:0] keys;
  logic                        locked, plain_used, wipe, plain_take;

  kv_rst_sync u_frst (.clk(clk), .arst_n(rst_n),     .srst_n(frst_n));
  kv_rst_sync u_krst (.clk(clk), .arst_n(key_rst_n), .srst_n(krst_n));

  kv_cmd_shifter #(.KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_cmd (
    .clk(clk), .rst_n(frst_n), .shift(tp_shift), .sdi(tp_sdi), .update(tp_update),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_data(cmd_data)
  );

  kv_key_vault #(.KEY_W(KEY_W), .NSETS(NSETS), .SLOT_W(SLOT_W)) u_vault (
    .clk(clk), .rst_n(frst_n), .krst_n(krst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
    .plain_take(plain_take), .keys_o(keys), .locked_o(locked),
    .plain_used_o(plain_used), .wipe_o(wipe), .rb_key_o(rb_key), .cmd_err_o(cmd_err)
  );

  kv_stream_gate #(.KEY_W(KEY_W), .NSETS(NSETS), .KSEL_W(KSEL_W), .SLOT_W(SLOT_W)) u_gate (
    .clk(clk), .rst_n(frst_n), .krst_n(krst_n),
    .locked(locked), .plain_used(plain_used), .keys(keys), .wipe(wipe),
    .st_start(st_start), .st_enc(st_enc), .st_ksel(st_ksel),
    .st_end(st_end), .st_ok(st_ok), .plain_take(plain_take),
    .dec_en(dec_en), .dec_key(dec_key), .dec_sel(dec_sel),
    .cfg_done(cfg_done), .cfg_fail(cfg_fail)
  );

  assign secure = locked;

endmodule

// File: tb/cfg_key_vault_tb_top.sv
`timescale 1ns/1ps
module cfg_key_vault_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, key_rst_n;
  logic        tp_shift, tp_sdi, tp_update;
  logic [55:0] rb_key, dec_key;
  logic        cmd_err, secure, dec_en, cfg_done, cfg_fail;
  logic [0:0]  dec_sel;
  logic        st_start, st_enc, st_end, st_ok;
  logic [1:0]  st_ksel;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  localparam logic [55:0] K0 = 56'hA1B2C3D4E5F607;
  localparam logic [55:0] K1 = 56'h0F1E2D3C4B5A69;
  localparam logic [55:0] KX = 56'hDEADBEEFCAFE11;
  localparam logic [55:0] K3 = 56'h13572468ACE0BD;

  always #5 clk = ~clk;

  cfg_key_vault dut_i (
    .clk(clk), .rst_n(rst_n), .key_rst_n(key_rst_n),
    .tp_shift(tp_shift), .tp_sdi(tp_sdi), .tp_update(tp_update),
    .rb_key(rb_key), .cmd_err(cmd_err), .secure(secure),
    .st_start(st_start), .st_enc(st_enc), .st_ksel(st_ksel),
    .st_end(st_end), .st_ok(st_ok),
    .dec_en(dec_en), .dec_key(dec_key), .dec_sel(dec_sel),
    .cfg_done(cfg_done), .cfg_fail(cfg_fail)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_frame(logic [2:0] op, logic slot, logic [55:0] data);
    logic [59:0] fr;
    fr = {op, slot, data};
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      tp_shift = 1'b1;
      tp_sdi   = fr[i];
    end
    @(negedge clk);
    tp_shift = 1'b0;
  endtask

  task automatic send_cmd(logic [2:0] op, logic slot, logic [55:0] data);
    shift_frame(op, slot, data);
    tp_update = 1'b1;
    @(negedge clk);
    tp_update = 1'b0;
    @(negedge clk);
  endtask

  task automatic stream_start(logic enc, logic [1:0] ksel);
    st_start = 1'b1; st_enc = enc; st_ksel = ksel;
    @(negedge clk);
    st_start = 1'b0;
  endtask

  task automatic stream_end(logic ok);
    st_end = 1'b1; st_ok = ok;
    @(negedge clk);
    st_end = 1'b0; st_ok = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9 reset cfg_done", 64'(cfg_done), 64'd0);
    chk("R9 reset cfg_fail", 64'(cfg_fail), 64'd0);
    chk("R9 reset cmd_err", 64'(cmd_err), 64'd0);
    chk("R10 reset secure", 64'(secure), 64'd0);
    chk("R7 reset dec_en", 64'(dec_en), 64'd0);
    chk("R1 reset rb_key", 64'(rb_key), 64'd0);
  endtask

  task automatic t_write_read();
    send_cmd(3'd1, 1'b0, K0);
    send_cmd(3'd1, 1'b1, K1);
    send_cmd(3'd2, 1'b0, '0);
    chk("R1 R13 read set0", 64'(rb_key), 64'(K0));
    send_cmd(3'd2, 1'b1, '0);
    chk("R1 read set1", 64'(rb_key), 64'(K1));
    send_cmd(3'd7, 1'b0, KX);
    send_cmd(3'd2, 1'b0, '0);
    chk("R13 unknown opcode no effect", 64'(rb_key), 64'(K0));
  endtask

  task automatic t_plain_once();
    stream_start(1'b1, 2'd0);
    chk("R4 encrypted before lock rejected", 64'(cfg_fail), 64'd1);
    stream_start(1'b0, 2'd0);
    chk("R4 first plaintext accepted", 64'(cfg_fail), 64'd0);
    chk("R4 plaintext no decrypt", 64'(dec_en), 64'd0);
    stream_end(1'b1);
    chk("R8 plaintext done", 64'(cfg_done), 64'd1);
    stream_start(1'b0, 2'd0);
    chk("R4 second plaintext rejected", 64'(cfg_fail), 64'd1);
    chk("R4 second plaintext done low", 64'(cfg_done), 64'd0);
  endtask

  task automatic t_lock_hides();
    send_cmd(3'd2, 1'b0, '0);
    chk("R1 captured before lock", 64'(rb_key), 64'(K0));
    send_cmd(3'd3, 1'b0, '0);
    chk("R2 secure after lock", 64'(secure), 64'd1);
    chk("R2 capture cleared", 64'(rb_key), 64'd0);
    send_cmd(3'd2, 1'b1, '0);
    chk("R2 read after lock zero", 64'(rb_key), 64'd0);
  endtask

  task automatic t_write_refused();
    send_cmd(3'd1, 1'b0, KX);
    chk("R3 cmd_err set", 64'(cmd_err), 64'd1);
    stream_start(1'b1, 2'd0);
    chk("R7 dec_en", 64'(dec_en), 64'd1);
    chk("R3 R7 key0 unchanged", 64'(dec_key), 64'(K0));
    chk("R7 dec_sel 0", 64'(dec_sel), 64'd0);
    stream_end(1'b0);
    chk("R8 bad stream done low", 64'(cfg_done), 64'd0);
    chk("R8 bad stream fail", 64'(cfg_fail), 64'd1);
    chk("R3 err sticky", 64'(cmd_err), 64'd1);
  endtask

  task automatic t_enc_set1();
    stream_start(1'b1, 2'd1);
    chk("R7 key1 routed", 64'(dec_key), 64'(K1));
    chk("R7 dec_sel 1", 64'(dec_sel), 64'd1);
    stream_end(1'b1);
    chk("R8 good stream done", 64'(cfg_done), 64'd1);
    chk("R7 dec_en off after end", 64'(dec_en), 64'd0);
  endtask

  task automatic t_rejects_locked();
    stream_start(1'b0, 2'd0);
    chk("R5 plaintext locked fail", 64'(cfg_fail), 64'd1);
    chk("R5 plaintext locked done low", 64'(cfg_done), 64'd0);
    stream_start(1'b1, 2'd2);
    chk("R6 ksel 2 rejected", 64'(cfg_fail), 64'd1);
    chk("R6 ksel 2 no decrypt", 64'(dec_en), 64'd0);
    stream_start(1'b1, 2'd3);
    chk("R6 ksel 3 rejected", 64'(cfg_fail), 64'd1);
  endtask

  task automatic t_func_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 lock kept", 64'(secure), 64'd1);
    chk("R9 err cleared", 64'(cmd_err), 64'd0);
    chk("R9 fail cleared", 64'(cfg_fail), 64'd0);
    stream_start(1'b1, 2'd1);
    chk("R9 key1 kept", 64'(dec_key), 64'(K1));
  endtask

  task automatic t_wipe_vs_end();
    shift_frame(3'd4, 1'b0, '0);
    tp_update = 1'b1;
    @(negedge clk);
    tp_update = 1'b0;
    st_end = 1'b1; st_ok = 1'b1;
    @(negedge clk);
    st_end = 1'b0; st_ok = 1'b0;
    chk("R12 wipe beats end, done low", 64'(cfg_done), 64'd0);
    chk("R11 lock dropped", 64'(secure), 64'd0);
    chk("R11 decrypt stopped", 64'(dec_en), 64'd0);
    send_cmd(3'd2, 1'b1, '0);
    chk("R11 key1 erased", 64'(rb_key), 64'd0);
    send_cmd(3'd2, 1'b0, '0);
    chk("R11 key0 erased", 64'(rb_key), 64'd0);
    stream_start(1'b0, 2'd0);
    chk("R11 fresh plaintext accepted", 64'(cfg_fail), 64'd0);
    stream_end(1'b1);
    chk("R11 fresh plaintext done", 64'(cfg_done), 64'd1);
    send_cmd(3'd4, 1'b0, '0);
    chk("R11 wipe drops done", 64'(cfg_done), 64'd0);
  endtask

  task automatic t_key_reset();
    send_cmd(3'd1, 1'b1, K3);
    send_cmd(3'd2, 1'b1, '0);
    chk("R1 set1 rewritten", 64'(rb_key), 64'(K3));
    send_cmd(3'd3, 1'b0, '0);
    chk("R2 relocked", 64'(secure), 64'd1);
    @(negedge clk); key_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    key_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 lock cleared", 64'(secure), 64'd0);
    send_cmd(3'd2, 1'b1, '0);
    chk("R10 key1 cleared", 64'(rb_key), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; key_rst_n = 1'b0;
    tp_shift = 1'b0; tp_sdi = 1'b0; tp_update = 1'b0;
    st_start = 1'b0; st_enc = 1'b0; st_ksel = 2'd0; st_end = 1'b0; st_ok = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; key_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write_read();
    t_plain_once();
    t_lock_hides();
    t_write_refused();
    t_enc_set1();
    t_rejects_locked();
    t_func_reset();
    t_wipe_vs_end();
    t_key_reset();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule